// File: doc/BRIEF.md
# Target Read Prefetch Controller

This block sits inside a bus-target bridge. It turns an upstream master read into reads on a local memory port, and it decides how far past the requested word it keeps reading into a read FIFO. Every local word that returns is pushed into the FIFO. After the requested word, the controller either stops at once, reads a fixed number of further sequential words, or keeps streaming for as long as the FIFO has room.

A 3-bit prefetch setting comes with each request. It belongs to the address space being read, and the block latches it when a fresh fetch starts. A global read-ahead enable changes two things. Reads can then be served from data already in the FIFO. It also changes when a streaming fetch stops.

Any request that cannot be served from the FIFO flushes the FIFO and restarts the local fetch at the new address. A separate flush input discards prefetched data and stops the local port.

Top module: `tgt_prefetch_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `lb_req`, `fifo_push`, `fifo_flush` and `up_hit` are all low.
- R2: A request that is not a hit pulses `fifo_flush` in the next cycle and drives `lb_req` high with `lb_addr` equal to the request address with bits [1:0] cleared. After each accepted beat (`lb_req` and `lb_ack` high together), `lb_addr` advances by 4.
- R3: `fifo_push` is high only in the cycle after an accepted beat, and `fifo_wdata` then carries that beat's `lb_rdata`. A beat accepted in the same cycle as a restart or a flush is not pushed.
- R4: Setting bit 2 = 1 selects counted mode. Bits [1:0] give the number of words read after the requested one: 00 gives 0, 01 gives 4, 10 gives 8 and 11 gives 16. A counted fetch makes exactly 1 + that number of beats, and `up_done` has no effect on it.
- R5: A request with `up_io` high, or with setting 100, makes exactly one beat, and an I/O request is never a hit.
- R6: With setting bit 2 = 0 and read-ahead off (streaming mode), the fetch continues while the FIFO has room. If `up_done` is high in cycle t, `lb_req` may remain high through cycle t+STOP_DLY and is low from cycle t+STOP_DLY+1.
- R7: With setting bit 2 = 0 and read-ahead on, the fetch continues until the FIFO holds DEPTH words, whatever `up_done` does.
- R8: A request is a hit when all of these hold: read-ahead is on, the space is memory, the previous request address is still known, the address equals that previous address + 4, address bits [1:0] are 0, and the FIFO is not empty. A hit raises `up_hit` in the next cycle, with no flush and no new fetch.
- R9: A request with read-ahead off, a non-sequential address, a misaligned address or an empty FIFO is not a hit, and restarts as in R2.
- R10: `flush_in` pulses `fifo_flush` in the next cycle, drops `lb_req`, and makes the next request a miss. A request in the same cycle as `flush_in` is a miss.
- R11: `lb_req` never asks for a word that the FIFO has no room left to hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | One-cycle upstream read request |
| up_addr | input | AW | Byte address of the request |
| up_io | input | 1 | Addressed space is I/O-mapped |
| up_pf_cfg | input | 3 | Prefetch setting of the addressed space |
| ra_en | input | 1 | Global read-ahead enable |
| up_done | input | 1 | Upstream master has finished its read |
| flush_in | input | 1 | Discard prefetched data |
| up_hit | output | 1 | Request served from the FIFO |
| lb_req | output | 1 | Local read request |
| lb_addr | output | AW | Local word address |
| lb_ack | input | 1 | Local port accepts the beat, data valid |
| lb_rdata | input | DW | Local read data |
| fifo_push | output | 1 | Write one word into the FIFO |
| fifo_wdata | output | DW | FIFO write data |
| fifo_flush | output | 1 | Empty the FIFO |
| fifo_level | input | LVL_W | Current FIFO occupancy in words |

## Verification
The hit test and the flush input can act in the same cycle. The bench first loads a read-ahead fetch, so that a request at the previous address + 4 would be a hit. It then raises that request and `flush_in` together. It expects `up_hit` to stay low, `fifo_flush` to pulse, and a fresh local fetch to start at the request address. A second collision is `up_done` arriving during a streaming fetch with read-ahead off. There the bench checks the exact number of beats against the STOP_DLY window, and with read-ahead on it expects a full FIFO instead.

// File: rtl/tpf_pkg.sv
package tpf_pkg;

  typedef enum logic [1:0] {
    PF_ONE       = 2'd0,
    PF_COUNT     = 2'd1,
    PF_STREAM    = 2'd2,
    PF_STREAM_RA = 2'd3
  } pf_mode_e;

  localparam int CNT_W = 5;

  // total beats of a counted fetch: requested word plus 0/4/8/16
  function automatic logic [CNT_W-1:0] count_limit(input logic [1:0] sel);
    logic [CNT_W-1:0] lim;
    unique case (sel)
      2'd0:    lim = CNT_W'(1);
      2'd1:    lim = CNT_W'(5);
      2'd2:    lim = CNT_W'(9);
      default: lim = CNT_W'(17);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/tpf_cfg_decode.sv
module tpf_cfg_decode
  import tpf_pkg::*;
(
  input  logic [2:0]       cfg,
  input  logic             io_space,
  input  logic             ra_en,
  output pf_mode_e         mode,
  output logic [CNT_W-1:0] limit
);
  always_comb begin
    limit = count_limit(cfg[1:0]);
    if (io_space || (cfg[2] && cfg[1:0] == 2'b00)) begin
      mode = PF_ONE;
    end else if (cfg[2]) begin
      mode = PF_COUNT;
    end else if (ra_en) begin
      mode = PF_STREAM_RA;
    end else begin
      mode = PF_STREAM;
    end
  end
endmodule

// File: rtl/tpf_seq_check.sv
module tpf_seq_check #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] prev_addr,
  input  logic          prev_valid,
  input  logic          ra_en,
  input  logic          req_io,
  input  logic          fifo_has_data,
  input  logic          flush_now,
  output logic          hit
);
  logic seq_ok;
  always_comb begin
    seq_ok = (req_addr[1:0] == 2'b00) && (req_addr == prev_addr + AW'(4));
    hit    = ra_en && !req_io && prev_valid && fifo_has_data && !flush_now && seq_ok;
  end
endmodule

// File: rtl/tpf_stop_timer.sv
module tpf_stop_timer #(
  parameter int STOP_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic done,
  output logic expired
);
  localparam int TW = (STOP_DLY < 2) ? 1 : $clog2(STOP_DLY + 1);

  logic          seen_q;
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q <= 1'b0;
      tmr_q  <= '0;
    end else if (done) begin
      seen_q <= 1'b1;
      tmr_q  <= TW'(STOP_DLY - 1);
    end else if (tmr_q != '0) begin
      tmr_q  <= tmr_q - TW'(1);
    end
  end

  assign expired = seen_q && (tmr_q == '0);
endmodule

// File: rtl/tgt_prefetch_ctrl.sv
module tgt_prefetch_ctrl
  import tpf_pkg::*;
#(
  parameter  int AW       = 32,
  parameter  int DW       = 32,
  parameter  int DEPTH    = 32,
  parameter  int STOP_DLY = 2,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req,
  input  logic [AW-1:0]    up_addr,
  input  logic             up_io,
  input  logic [2:0]       up_pf_cfg,
  input  logic             ra_en,
  input  logic             up_done,
  input  logic             flush_in,
  output logic             up_hit,
  output logic             lb_req,
  output logic [AW-1:0]    lb_addr,
  input  logic             lb_ack,
  input  logic [DW-1:0]    lb_rdata,
  output logic             fifo_push,
  output logic [DW-1:0]    fifo_wdata,
  output logic             fifo_flush,
  input  logic [LVL_W-1:0] fifo_level
);

  logic [AW-1:0]    last_addr_q;
  logic             last_valid_q;
  logic [2:0]       cfg_q;
  logic             io_q;
  logic [CNT_W-1:0] beat_cnt_q;
  logic             hit_q, push_q, flush_q, req_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;

  logic             beat, hit, restart, room, want_more, stop_now, expired;
  logic [LVL_W:0]   occ_now, occ_next;
  logic [CNT_W-1:0] beat_total, limit;
  pf_mode_e         mode;

  tpf_cfg_decode u_dec (
    .cfg      (cfg_q),
    .io_space (io_q),
    .ra_en    (ra_en),
    .mode     (mode),
    .limit    (limit)
  );

  tpf_seq_check #(.AW(AW)) u_seq (
    .req_addr      (up_addr),
    .prev_addr     (last_addr_q),
    .prev_valid    (last_valid_q),
    .ra_en         (ra_en),
    .req_io        (up_io),
    .fifo_has_data (occ_now != '0),
    .flush_now     (flush_in),
    .hit           (hit)
  );

  tpf_stop_timer #(.STOP_DLY(STOP_DLY)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (restart),
    .done    (up_done),
    .expired (expired)
  );

  always_comb begin
    beat       = req_q && lb_ack;
    restart    = up_req && !hit;
    // occupancy after pending flush and the push still in flight
    occ_now    = (flush_q ? '0 : {1'b0, fifo_level}) + {{LVL_W{1'b0}}, push_q};
    occ_next   = occ_now + {{LVL_W{1'b0}}, beat};
    room       = occ_next < (LVL_W + 1)'(DEPTH);
    beat_total = beat_cnt_q + CNT_W'(1);
    stop_now   = (mode == PF_STREAM) && expired;
    unique case (mode)
      PF_ONE:   want_more = 1'b0;
      PF_COUNT: want_more = beat_total < limit;
      default:  want_more = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr_q  <= '0;
      last_valid_q <= 1'b0;
      cfg_q        <= '0;
      io_q         <= 1'b0;
      beat_cnt_q   <= '0;
      hit_q        <= 1'b0;
      push_q       <= 1'b0;
      flush_q      <= 1'b0;
      req_q        <= 1'b0;
      addr_q       <= '0;
      wdata_q      <= '0;
    end else begin
      hit_q   <= up_req && hit;
      push_q  <= beat && !restart && !flush_in;
      flush_q <= restart || flush_in;
      if (beat) wdata_q <= lb_rdata;

      if (up_req) begin
        last_addr_q  <= up_addr;
        last_valid_q <= !up_io;
      end else if (flush_in) begin
        last_valid_q <= 1'b0;
      end

      if (restart) begin
        req_q      <= 1'b1;
        addr_q     <= {up_addr[AW-1:2], 2'b00};
        beat_cnt_q <= '0;
        cfg_q      <= up_pf_cfg;
        io_q       <= up_io;
      end else if (flush_in) begin
        req_q <= 1'b0;
      end else if (beat) begin
        addr_q     <= addr_q + AW'(4);
        beat_cnt_q <= beat_total;
        req_q      <= want_more && room && !stop_now;
      end else if (stop_now) begin
        req_q <= 1'b0;
      end
    end
  end

  assign up_hit     = hit_q;
  assign lb_req     = req_q;
  assign lb_addr    = addr_q;
  assign fifo_push  = push_q;
  assign fifo_wdata = wdata_q;
  assign fifo_flush = flush_q;

endmodule

// File: rtl/tpf_checker.sv
module tpf_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          up_req,
  input logic [1:0]    up_addr_lo,
  input logic          up_io,
  input logic          ra_en,
  input logic          flush_in,
  input logic          up_hit,
  input logic          lb_req,
  input logic [AW-1:0] lb_addr,
  input logic          lb_ack,
  input logic [DW-1:0] lb_rdata,
  input logic          fifo_push,
  input logic [DW-1:0] fifo_wdata,
  input logic          fifo_flush
);

  AST_PUSH_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> $past(lb_req && lb_ack)); // R3

  AST_PUSH_DATA: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> fifo_wdata == $past(lb_rdata)); // R3

  AST_FLUSH_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> !fifo_push); // R3

  AST_LB_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    lb_req |-> lb_addr[1:0] == 2'b00); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (lb_req && lb_ack && !up_req && !flush_in) |=> lb_addr == $past(lb_addr) + AW'(4)); // R2

  AST_HIT_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    up_hit |-> !fifo_flush); // R8

  AST_HIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    up_hit |-> $past(up_req && ra_en && !up_io && up_addr_lo == 2'b00 && !flush_in)); // R10

  AST_RA_OFF_MISS: assert property (@(posedge clk) disable iff (rst)
    (up_req && !ra_en) |=> fifo_flush && lb_req && !up_hit); // R9

  AST_IO_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (up_req && up_io) |=> !up_hit); // R5

  AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    flush_in |=> fifo_flush); // R10

endmodule

bind tgt_prefetch_ctrl tpf_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .up_req     (up_req),
  .up_addr_lo (up_addr[1:0]),
  .up_io      (up_io),
  .ra_en      (ra_en),
  .flush_in   (flush_in),
  .up_hit     (up_hit),
  .lb_req     (lb_req),
  .lb_addr    (lb_addr),
  .lb_ack     (lb_ack),
  .lb_rdata   (lb_rdata),
  .fifo_push  (fifo_push),
  .fifo_wdata (fifo_wdata),
  .fifo_flush (fifo_flush)
);

// File: tb/tb_tgt_prefetch_ctrl.sv
module tb_tgt_prefetch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DEPTH = 32;
  localparam int STOP_DLY = 2;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int WD_LIMIT = 100000;
  localparam logic [31:0] MASK = 32'hA5A5_0000;

  localparam int NV = 10;
  localparam logic [2:0]  V_CFG   [NV] = '{3'b100, 3'b101, 3'b110, 3'b111, 3'b011,
                                           3'b000, 3'b010, 3'b000, 3'b101, 3'b111};
  localparam logic        V_IO    [NV] = '{0, 0, 0, 0, 1, 0, 0, 0, 0, 1};
  localparam logic        V_RA    [NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 1};
  localparam logic        V_STALL [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 0, 0};
  localparam logic [31:0] V_ADDR  [NV] = '{32'h1000, 32'h1102, 32'h1200, 32'h1300, 32'h1400,
                                           32'h1500, 32'h1600, 32'h1700, 32'h1800, 32'h1900};
  localparam int          V_DONE  [NV] = '{-1, -1, -1, -1, -1, 3, -1, 3, 1, -1};
  localparam int          V_EXP   [NV] = '{1, 5, 9, 17, 1, DEPTH, DEPTH, 3 + STOP_DLY + 1, 5, 1};

  logic clk = 0, rst = 1;
  logic up_req = 0, up_io = 0, ra_en = 0, up_done = 0, flush_in = 0;
  logic [AW-1:0] up_addr = '0;
  logic [2:0] up_pf_cfg = '0;
  logic up_hit, lb_req, lb_ack, fifo_push, fifo_flush;
  logic [AW-1:0] lb_addr;
  logic [DW-1:0] lb_rdata, fifo_wdata;
  logic [LVL_W-1:0] fifo_level;
  logic stall = 0, drain_req = 0;
  int cyc = 0, n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign lb_ack   = stall ? cyc[0] : 1'b1;
  assign lb_rdata = lb_addr ^ MASK;

  tgt_prefetch_ctrl #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .STOP_DLY(STOP_DLY)) dut (
    .clk(clk), .rst(rst), .up_req(up_req), .up_addr(up_addr), .up_io(up_io),
    .up_pf_cfg(up_pf_cfg), .ra_en(ra_en), .up_done(up_done), .flush_in(flush_in),
    .up_hit(up_hit), .lb_req(lb_req), .lb_addr(lb_addr), .lb_ack(lb_ack),
    .lb_rdata(lb_rdata), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
    .fifo_flush(fifo_flush), .fifo_level(fifo_level)
  );

  // FIFO occupancy model (no pops except an explicit drain)
  always @(posedge clk) begin
    if (rst || drain_req || fifo_flush) fifo_level <= '0;
    else if (fifo_push)                 fifo_level <= fifo_level + 1'b1;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < %0d", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input logic [2:0] cfg, input logic io, input logic ra,
                           input logic [31:0] addr, input int done_at,
                           output int beats, output logic [31:0] first_a,
                           output int pushes, output int bad, output logic flushed);
    logic [31:0] prev_a;
    int idle;
    @(negedge clk);
    up_pf_cfg = cfg; up_io = io; ra_en = ra; up_addr = addr; up_req = 1;
    @(negedge clk);
    up_req = 0;
    flushed = fifo_flush;
    beats = 0; pushes = 0; bad = 0; idle = 0; prev_a = '0; first_a = '0;
    for (int k = 0; k < 400 && idle < 4; k++) begin
      up_done = (k == done_at);
      if (fifo_push) begin
        pushes++;
        if (beats == 0 || fifo_wdata != (prev_a ^ MASK)) bad++;
      end
      if (lb_req && lb_ack) begin
        if (beats == 0) first_a = lb_addr;
        beats++;
        prev_a = lb_addr;
      end
      idle = (lb_req || fifo_push) ? 0 : idle + 1;
      @(negedge clk);
    end
    up_done = 0;
  endtask

  task automatic seq_req(input logic [31:0] addr, input logic io, input logic ra, input logic fl,
                         output logic hit, output logic fls, output logic req, output logic [31:0] la);
    @(negedge clk);
    up_addr = addr; up_io = io; ra_en = ra; flush_in = fl; up_req = 1;
    @(negedge clk);
    up_req = 0; flush_in = 0;
    hit = up_hit; fls = fifo_flush; req = lb_req; la = lb_addr;
  endtask

  task automatic wait_idle();
    int idle = 0;
    for (int k = 0; k < 400 && idle < 3; k++) begin
      @(negedge clk);
      idle = (lb_req || fifo_push) ? 0 : idle + 1;
    end
  endtask

  task automatic drain();
    @(negedge clk); drain_req = 1;
    @(negedge clk); drain_req = 0;
  endtask

  initial begin
    int beats, pushes, bad;
    logic [31:0] fa, la;
    logic fl, hit, fls, req;

    // R1: reset state
    repeat (4) @(negedge clk);
    check(!lb_req && !fifo_push && !fifo_flush && !up_hit, "R1 outputs in reset",
          {lb_req, fifo_push, fifo_flush, up_hit}, 0);
    rst = 0;
    @(negedge clk);
    check(!lb_req && !fifo_push && !fifo_flush && !up_hit, "R1 first cycle after reset",
          {lb_req, fifo_push, fifo_flush, up_hit}, 0);

    // table of fetch vectors: R4 R5 R6 R7 beat counts, R2 address, R3 pushes
    for (int v = 0; v < NV; v++) begin
      stall = V_STALL[v];
      run_fetch(V_CFG[v], V_IO[v], V_RA[v], V_ADDR[v], V_DONE[v], beats, fa, pushes, bad, fl);
      stall = 0;
      check(beats == V_EXP[v], $sformatf("R4/R5/R6/R7 beats vector %0d", v), beats, V_EXP[v]);
      check(fa == {V_ADDR[v][31:2], 2'b00}, $sformatf("R2 first address vector %0d", v),
            fa, {V_ADDR[v][31:2], 2'b00});
      check(fl, $sformatf("R2 restart flush vector %0d", v), fl, 1);
      check(pushes == beats && bad == 0, $sformatf("R3 pushes and data vector %0d", v),
            pushes - bad, beats);
    end

    // R8: sequential aligned read-ahead hits
    run_fetch(3'b101, 0, 1, 32'h2000, -1, beats, fa, pushes, bad, fl);
    seq_req(32'h2004, 0, 1, 0, hit, fls, req, la);
    check(hit && !fls && !req, "R8 hit at +4", {hit, fls, req}, 3'b100);
    seq_req(32'h2008, 0, 1, 0, hit, fls, req, la);
    check(hit && !fls && !req, "R8 second hit at +4", {hit, fls, req}, 3'b100);
    // R9: skipped address misses
    seq_req(32'h2010, 0, 1, 0, hit, fls, req, la);
    check(!hit && fls && req && la == 32'h2010, "R9 non-sequential miss", la, 32'h2010);
    wait_idle();

    // R9: misaligned sequential address
    run_fetch(3'b100, 0, 1, 32'h3002, -1, beats, fa, pushes, bad, fl);
    seq_req(32'h3006, 0, 1, 0, hit, fls, req, la);
    check(!hit && fls && req && la == 32'h3004, "R9 misaligned miss", la, 32'h3004);
    wait_idle();

    // R9: read-ahead off
    run_fetch(3'b100, 0, 0, 32'h3100, -1, beats, fa, pushes, bad, fl);
    seq_req(32'h3104, 0, 0, 0, hit, fls, req, la);
    check(!hit && fls && req, "R9 read-ahead off miss", {hit, fls, req}, 3'b011);
    wait_idle();

    // R9: empty FIFO versus one word present (R8)
    run_fetch(3'b100, 0, 1, 32'h3200, -1, beats, fa, pushes, bad, fl);
    drain();
    seq_req(32'h3204, 0, 1, 0, hit, fls, req, la);
    check(!hit && fls && req, "R9 empty FIFO miss", {hit, fls, req}, 3'b011);
    wait_idle();
    run_fetch(3'b100, 0, 1, 32'h3300, -1, beats, fa, pushes, bad, fl);
    seq_req(32'h3304, 0, 1, 0, hit, fls, req, la);
    check(hit && !fls && !req, "R8 one word in FIFO hits", {hit, fls, req}, 3'b100);

    // R5: I/O sequential request never hits
    seq_req(32'h3308, 1, 1, 0, hit, fls, req, la);
    check(!hit && fls && req, "R5 I/O request is not a hit", {hit, fls, req}, 3'b011);
    wait_idle();

    // R10: flush alone forgets previous address
    run_fetch(3'b101, 0, 1, 32'h4000, -1, beats, fa, pushes, bad, fl);
    @(negedge clk); flush_in = 1;
    @(negedge clk); flush_in = 0;
    check(fifo_flush, "R10 flush pulse", fifo_flush, 1);
    seq_req(32'h4004, 0, 1, 0, hit, fls, req, la);
    check(!hit && req && la == 32'h4004, "R10 miss after flush", {hit, req}, 2'b01);
    wait_idle();

    // R10: flush in same cycle as a would-be hit
    run_fetch(3'b101, 0, 1, 32'h4100, -1, beats, fa, pushes, bad, fl);
    seq_req(32'h4104, 0, 1, 1, hit, fls, req, la);
    check(!hit && fls && req && la == 32'h4104, "R10 flush beats hit", {hit, fls, req}, 3'b011);
    wait_idle();

    // R10 / R11: flush stops a streaming fetch
    up_pf_cfg = 3'b000;
    seq_req(32'h4200, 0, 1, 0, hit, fls, req, la);
    check(req && !hit, "R7 streaming fetch starts", {hit, req}, 2'b01);
    repeat (2) @(negedge clk);
    flush_in = 1;
    @(negedge clk); flush_in = 0;
    check(fifo_flush && !lb_req, "R10 flush drops local request", {fifo_flush, lb_req}, 2'b10);
    repeat (3) @(negedge clk);
    check(!lb_req, "R10 local port stays idle", lb_req, 0);

    // R11: full FIFO, new streaming fetch after a drain-free restart fills exactly DEPTH
    run_fetch(3'b000, 0, 1, 32'h4400, -1, beats, fa, pushes, bad, fl);
    check(fifo_level == LVL_W'(DEPTH) && !lb_req, "R11 stops at full FIFO", fifo_level, DEPTH);

    summary();
    $finish;
  end
endmodule